// File: doc/BRIEF.md
# Audio Reference Clock Source Selector

This block decides which incoming audio clock feeds the downstream clock generator. Two candidate references arrive as single-cycle edge strobes: the master clock and the serial bit clock. A third strobe marks the start of each word-select frame. All three are already synchronised to a free-running reference clock. For each candidate, the block counts its edges over one frame. A frame is good when that count lies within a small tolerance of one entry in that clock's list of allowed ratios.

A candidate becomes valid only after a run of consecutive good frames, and it loses validity only after a run of the same length of bad frames. A candidate whose edges stop for longer than an idle timeout is dropped at once. The master clock wins whenever it is valid. When it is not, the bit clock is used. When neither is valid, no source is selected. Because the serial audio data cannot be captured without a working bit clock, the block requests high-impedance outputs whenever the bit clock is not valid.

Top module: `clksrc_select`

## Requirements
- R1: While and right after reset, `mclk_valid` and `bclk_valid` are 0, `src_sel` is 0 (no source) and `out_hiz` is 1.
- R2: A frame is good for a clock when the number of its edge strobes counted since the previous word-select strobe, including any edge in the word-select cycle itself, differs by at most TOL from one entry of that clock's ratio list. Any other count is a bad frame.
- R3: An invalid clock becomes valid in the cycle after the word-select strobe that ends its PERSIST-th consecutive good frame. A bad frame or an idle timeout restarts the run.
- R4: A valid clock becomes invalid in the cycle after the word-select strobe that ends its PERSIST-th consecutive bad frame. A good frame in between restarts the run.
- R5: When a clock has had no edge strobe for TIMEOUT reference cycles, its valid flag drops on the next clock edge and stays low until edges resume and R3 is met again.
- R6: Whenever `mclk_valid` is 1, `src_sel` is 1 (master clock), whatever the bit clock state.
- R7: When `mclk_valid` is 0 and `bclk_valid` is 1, `src_sel` is 2 (bit clock).
- R8: When both valid flags are 0, `src_sel` is 0 (no source).
- R9: `out_hiz` is 1 exactly when `bclk_valid` is 0, in the same cycle.
- R10: The first word-select strobe after reset only opens the counting window. Its frame counts as neither good nor bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_stb | input | 1 | One-cycle strobe per master clock edge |
| bclk_stb | input | 1 | One-cycle strobe per bit clock edge |
| ws_stb | input | 1 | One-cycle strobe at each word-select frame start |
| src_sel | output | 2 | Selected reference: 0 none, 1 master clock, 2 bit clock |
| mclk_valid | output | 1 | Master clock currently judged valid |
| bclk_valid | output | 1 | Bit clock currently judged valid |
| out_hiz | output | 1 | Request to put the audio outputs in high impedance |

## Verification
The bench builds the block with 8-bit counters and ratio lists of {32, 48, 64} for the master clock and {8, 12, 16} for the bit clock. It uses a tolerance of 1, runs of 3 frames and an idle timeout of 20 cycles. Every frame is 80 reference cycles long, with the edges spread evenly inside it. With these values, one bench run covers acquisition, an interrupted drop run, a full drop, a fallback to the bit clock, both idle timeouts and recovery, each within a few hundred cycles. The edge counts chosen include values exactly one away from a list entry and values two away, so the edges of the tolerance window are exercised.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Source chosen for the downstream clock generator
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MCLK = 2'd1,
        SRC_BCLK = 2'd2
    } clk_src_e;

    // Result of arbitration between the two candidates
    typedef struct packed {
        clk_src_e src;
        logic     hiz;
    } route_t;

    // True when got lies within +/- tol of want
    function automatic logic near(input int unsigned got,
                                  input int unsigned want,
                                  input int unsigned tol);
        return ((got + tol) >= want) && (got <= (want + tol));
    endfunction

endpackage

// File: rtl/audclk_ratio_match.sv
module audclk_ratio_match
    import audclk_pkg::*;
#(
    parameter int                    CNT_W = 12,
    parameter int                    N     = 3,
    parameter int                    TOL   = 1,
    parameter logic [N*CNT_W-1:0]    LIST  = '0
) (
    input  logic [CNT_W:0] count,
    output logic           hit
);
    logic [N-1:0] hit_v;

    // One window comparator per allowed ratio
    for (genvar i = 0; i < N; i++) begin : g_win
        assign hit_v[i] = near(32'(count), 32'(LIST[i*CNT_W +: CNT_W]), 32'(TOL));
    end

    assign hit = |hit_v;
endmodule

// File: rtl/audclk_rate_check.sv
module audclk_rate_check
    import audclk_pkg::*;
#(
    parameter int                 CNT_W   = 12,
    parameter int                 N       = 3,
    parameter int                 TOL     = 1,
    parameter logic [N*CNT_W-1:0] LIST    = '0,
    parameter int                 PERSIST = 4,
    parameter int                 TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_stb,
    input  logic frame_stb,
    output logic ok
);
    localparam int SUM_W  = CNT_W + 1;
    localparam int RUN_W  = $clog2(PERSIST + 1);
    localparam int IDLE_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  frame_cnt;
    logic [IDLE_W-1:0] idle_q;
    logic [RUN_W-1:0]  run_q;
    logic              primed_q;
    logic              ok_q;
    logic              hit;
    logic              dead;

    // Edge total for the frame closing this cycle
    assign frame_cnt = {1'b0, cnt_q} + SUM_W'(edge_stb);
    assign dead      = (idle_q == IDLE_W'(TIMEOUT));

    audclk_ratio_match #(
        .CNT_W (CNT_W),
        .N     (N),
        .TOL   (TOL),
        .LIST  (LIST)
    ) u_match (
        .count (frame_cnt),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            idle_q   <= '0;
            run_q    <= '0;
            primed_q <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            primed_q <= primed_q | frame_stb;

            if (frame_stb)
                cnt_q <= '0;
            else if (edge_stb && (cnt_q != '1))
                cnt_q <= cnt_q + CNT_W'(1);

            if (edge_stb)
                idle_q <= '0;
            else if (!dead)
                idle_q <= idle_q + IDLE_W'(1);

            if (dead) begin
                ok_q  <= 1'b0;
                run_q <= '0;
            end else if (frame_stb && primed_q) begin
                if (hit == ok_q)
                    run_q <= '0;
                else if (run_q == RUN_W'(PERSIST - 1)) begin
                    ok_q  <= ~ok_q;
                    run_q <= '0;
                end else
                    run_q <= run_q + RUN_W'(1);
            end
        end
    end

    assign ok = ok_q;

    // R5: a stalled clock is dropped on the next edge
    assert_dead_drops_R5: assert property (@(posedge clk) disable iff (rst)
        dead |=> !ok_q);

    // R3: acquisition only happens at a frame boundary
    assert_rise_at_frame_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(frame_stb));

    // R4: loss only at a frame boundary or after a stall
    assert_fall_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ok_q) |-> ($past(frame_stb) || $past(dead)));

    // R10: nothing is judged before the first window opens
    assert_unprimed_R10: assert property (@(posedge clk) disable iff (rst)
        !primed_q |-> !ok_q);

    // R3: the run counter never passes its limit
    assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run_q < RUN_W'(PERSIST));
endmodule

// File: rtl/audclk_src_arbiter.sv
module audclk_src_arbiter
    import audclk_pkg::*;
(
    input  logic   mclk_ok,
    input  logic   bclk_ok,
    output route_t route
);
    always_comb begin
        route.hiz = ~bclk_ok;
        if (mclk_ok)
            route.src = SRC_MCLK;
        else if (bclk_ok)
            route.src = SRC_BCLK;
        else
            route.src = SRC_NONE;
    end
endmodule

// File: rtl/clksrc_select.sv
module clksrc_select
    import audclk_pkg::*;
#(
    parameter int                        CNT_W       = 12,
    parameter int                        TOL         = 1,
    parameter int                        PERSIST     = 4,
    parameter int                        TIMEOUT     = 64,
    parameter int                        MCLK_N      = 3,
    parameter logic [MCLK_N*CNT_W-1:0]   MCLK_RATIOS = {12'd512, 12'd384, 12'd256},
    parameter int                        BCLK_N      = 3,
    parameter logic [BCLK_N*CNT_W-1:0]   BCLK_RATIOS = {12'd64, 12'd48, 12'd32}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_stb,
    input  logic       bclk_stb,
    input  logic       ws_stb,
    output logic [1:0] src_sel,
    output logic       mclk_valid,
    output logic       bclk_valid,
    output logic       out_hiz
);
    logic   m_ok;
    logic   b_ok;
    route_t route;

    audclk_rate_check #(
        .CNT_W   (CNT_W),
        .N       (MCLK_N),
        .TOL     (TOL),
        .LIST    (MCLK_RATIOS),
        .PERSIST (PERSIST),
        .TIMEOUT (TIMEOUT)
    ) u_mclk_chk (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (mclk_stb),
        .frame_stb (ws_stb),
        .ok        (m_ok)
    );

    audclk_rate_check #(
        .CNT_W   (CNT_W),
        .N       (BCLK_N),
        .TOL     (TOL),
        .LIST    (BCLK_RATIOS),
        .PERSIST (PERSIST),
        .TIMEOUT (TIMEOUT)
    ) u_bclk_chk (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (bclk_stb),
        .frame_stb (ws_stb),
        .ok        (b_ok)
    );

    audclk_src_arbiter u_arb (
        .mclk_ok (m_ok),
        .bclk_ok (b_ok),
        .route   (route)
    );

    assign src_sel    = route.src;
    assign mclk_valid = m_ok;
    assign bclk_valid = b_ok;
    assign out_hiz    = route.hiz;

    assert_mclk_priority_R6: assert property (@(posedge clk) disable iff (rst)
        mclk_valid |-> (src_sel == 2'd1));

    assert_bclk_fallback_R7: assert property (@(posedge clk) disable iff (rst)
        (!mclk_valid && bclk_valid) |-> (src_sel == 2'd2));

    assert_no_source_R8: assert property (@(posedge clk) disable iff (rst)
        (!mclk_valid && !bclk_valid) |-> (src_sel == 2'd0));

    assert_hiz_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        out_hiz == !bclk_valid);
endmodule

// File: tb/sim_clksrc_select.sv
`timescale 1ns/1ps
module sim_clksrc_select;
    localparam int TOL   = 1;
    localparam int PERS  = 3;
    localparam int TMO   = 20;
    localparam int FLEN  = 80;
    localparam int CMAX  = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk_stb = 1'b0;
    logic       bclk_stb = 1'b0;
    logic       ws_stb = 1'b0;
    logic [1:0] src_sel;
    logic       mclk_valid, bclk_valid, out_hiz;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    clksrc_select #(
        .CNT_W       (8),
        .TOL         (TOL),
        .PERSIST     (PERS),
        .TIMEOUT     (TMO),
        .MCLK_N      (3),
        .MCLK_RATIOS ({8'd64, 8'd48, 8'd32}),
        .BCLK_N      (3),
        .BCLK_RATIOS ({8'd16, 8'd12, 8'd8})
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .mclk_stb   (mclk_stb),
        .bclk_stb   (bclk_stb),
        .ws_stb     (ws_stb),
        .src_sel    (src_sel),
        .mclk_valid (mclk_valid),
        .bclk_valid (bclk_valid),
        .out_hiz    (out_hiz)
    );

    // ---------------- behavioural reference model ----------------
    int  m_cnt[2], m_idle[2], m_run[2];
    bit  m_ok[2], m_primed[2];
    int  lists[2][3] = '{'{32, 48, 64}, '{8, 12, 16}};

    function automatic bit fits(int s, int n);
        foreach (lists[s][k])
            if (n >= lists[s][k] - TOL && n <= lists[s][k] + TOL) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            bit e;
            int n;
            e = (s == 0) ? mclk_stb : bclk_stb;
            if (rst) begin
                m_cnt[s] = 0; m_idle[s] = 0; m_run[s] = 0;
                m_ok[s] = 0; m_primed[s] = 0;
            end else begin
                n = m_cnt[s] + int'(e);
                if (m_idle[s] == TMO) begin
                    m_ok[s] = 0; m_run[s] = 0;
                end else if (ws_stb && m_primed[s]) begin
                    if (fits(s, n) == m_ok[s]) m_run[s] = 0;
                    else if (m_run[s] == PERS - 1) begin
                        m_ok[s] = !m_ok[s]; m_run[s] = 0;
                    end else m_run[s]++;
                end
                if (ws_stb) m_cnt[s] = 0;
                else if (e && m_cnt[s] < CMAX) m_cnt[s]++;
                if (e) m_idle[s] = 0;
                else if (m_idle[s] < TMO) m_idle[s]++;
                if (ws_stb) m_primed[s] = 1;
            end
        end
    end

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            int es;
            es = m_ok[0] ? 1 : (m_ok[1] ? 2 : 0);
            chk(mclk_valid == m_ok[0], "R2/R3/R4/R5 mclk_valid", mclk_valid, m_ok[0]);
            chk(bclk_valid == m_ok[1], "R2/R3/R4/R5 bclk_valid", bclk_valid, m_ok[1]);
            chk(int'(src_sel) == es, "R6/R7/R8 src_sel", src_sel, es);
            chk(out_hiz == !m_ok[1], "R9 out_hiz", out_hiz, !m_ok[1]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit m, input bit b, input bit w);
        mclk_stb = m; bclk_stb = b; ws_stb = w;
        @(negedge clk);
    endtask

    // one frame of FLEN cycles with mn / bn evenly spread edges
    task automatic frame(input int mn, input int bn);
        for (int c = 0; c < FLEN; c++) begin
            bit m, b;
            m = (((c + 1) * mn) / FLEN) != ((c * mn) / FLEN);
            b = (((c + 1) * bn) / FLEN) != ((c * bn) / FLEN);
            step(m, b, c == FLEN - 1);
        end
    endtask

    task automatic expect_out(input string tag, input int ev_m, input int ev_b,
                              input int ev_s, input int ev_h);
        chk(mclk_valid == ev_m, {tag, " mclk_valid"}, mclk_valid, ev_m);
        chk(bclk_valid == ev_b, {tag, " bclk_valid"}, bclk_valid, ev_b);
        chk(int'(src_sel) == ev_s, {tag, " src_sel"}, src_sel, ev_s);
        chk(out_hiz == ev_h, {tag, " out_hiz"}, out_hiz, ev_h);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 1);
        rst = 1'b0;
        step(0, 0, 0);
        expect_out("R1 after reset", 0, 0, 0, 1);

        frame(32, 8);                          // opens the window only
        frame(33, 12);
        frame(33, 12);
        expect_out("R10 R3 two good frames", 0, 0, 0, 1);
        frame(31, 16);                         // third good frame, tolerance -1
        expect_out("R3 R2 R6 acquired", 1, 1, 1, 0);

        frame(40, 16);
        frame(40, 16);
        frame(49, 16);                         // good, restarts the bad run
        frame(40, 16);
        frame(40, 16);
        expect_out("R4 interrupted run", 1, 1, 1, 0);
        frame(40, 16);
        expect_out("R4 R7 mclk dropped", 0, 1, 2, 0);

        frame(0, 16);
        frame(0, 12);
        expect_out("R5 R7 mclk stalled", 0, 1, 2, 0);
        repeat (30) step(0, 0, 0);
        expect_out("R5 R8 R9 bclk stalled", 0, 0, 0, 1);

        frame(32, 0);
        frame(48, 0);
        frame(64, 0);
        expect_out("R6 R9 mclk only", 1, 0, 1, 1);

        frame(32, 10);
        frame(32, 10);
        frame(32, 10);
        expect_out("R2 count off by two", 1, 0, 1, 1);
        frame(32, 13);
        frame(32, 13);
        frame(32, 13);
        expect_out("R2 R9 count off by one", 1, 1, 1, 0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            finish_run();
        end
    end
endmodule